// File: doc/BRIEF.md
# Decompression Channel Controller

This block sits between an input FIFO of tagged bytes and the read side of a decompression channel. Each byte carries two tags: last-of-record and last-of-transfer. While the channel is enabled, the controller pops one byte per clock into a three-stage pipeline that carries the tags alongside the data. At the last stage the byte either goes through an external decode hook (a combinational port pair) or skips it unchanged, depending on the pass-through select. Finished bytes enter a small internal output FIFO, and the consumer reads them from there.

The end of a record or transfer is recognised when its tagged byte leaves the pipeline, which is the point where it is decoded. By then, up to three bytes of the following record may already be inside. If the halt-at-record or halt-at-transfer option is set, the controller clears its enable at that point. The trapped bytes are frozen and keep the empty flag low until software enables the channel again. The pass-through select can change only when the channel is both disabled and empty. An accepted change pulses a dictionary-clear output, and toggling the enable does not.

Two sticky status bits record that the last byte of a record or of a transfer was read out of the output FIFO. A masked OR of those bits drives the interrupt line. The configuration port is a single write strobe with a 2-bit address.

Top module: `dcc_chan_ctrl`

## Requirements
- R1: While enabled and the output FIFO is not full, the pipeline advances each clock, and `in_pop` is high in every such cycle where `in_empty` is low. When disabled or when the output FIFO is full, `in_pop` is low and the pipeline is frozen.
- R2: A byte popped at one clock edge is at the head of the output FIFO after the third following advancing edge. In decode mode the byte is replaced by `xf_out`, which is returned for the byte shown on `xf_in`. In pass-through mode it is delivered unaltered. Tags travel unchanged with the byte.
- R3: A write to address 1 sets the pass-through select from bit 0 only when enable is 0 and the empty flag is 1 in that cycle. Any other such write leaves `stat_pass` unchanged.
- R4: An accepted write that changes the pass-through select raises `dict_clr` for exactly one cycle. Writes that leave it equal, and every enable write, leave `dict_clr` low.
- R5: A write to address 0 loads enable from bit 0, halt-at-record from bit 1 and halt-at-transfer from bit 2. With halt-at-record set, the edge that moves a last-of-record byte into the output FIFO clears enable, and this clear overrides a same-cycle write.
- R6: With halt-at-transfer set, the edge that moves a last-of-transfer byte into the output FIFO clears enable in the same way.
- R7: Bytes left in the pipeline after a halt stay there unchanged, and `stat_empty` stays 0, until enable is set again. `stat_empty` is 1 exactly when no pipeline stage holds a byte.
- R8: Reading a byte tagged last-of-record sets status bit 0. Reading a byte tagged last-of-transfer sets status bit 1.
- R9: Status bits are sticky. Writing ones to address 2 clears the matching bits, and a set in the same cycle wins.
- R10: `irq` is the OR of the status bits that are enabled by the mask written to address 3 (bit 0 and bit 1).
- R11: After reset the channel is disabled, decode mode is selected, the pipeline and output FIFO are empty, status and mask are 0, and `irq` and `dict_clr` are low.
- R12: The output FIFO never accepts a byte while full. A read strobe while `rd_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_empty | input | 1 | Input FIFO has no byte |
| in_data | input | DW | Head byte of input FIFO |
| in_eor | input | 1 | Head byte is last of its record |
| in_eot | input | 1 | Head byte is last of its transfer |
| in_pop | output | 1 | Take the head byte this cycle |
| xf_in | output | DW | Byte presented to the decode hook |
| xf_out | input | DW | Decoded byte returned by the hook |
| rd_en | input | 1 | Consumer reads the head of the output FIFO |
| rd_valid | output | 1 | Output FIFO holds a byte |
| rd_data | output | DW | Head byte of output FIFO |
| rd_eor | output | 1 | Head byte is last of its record |
| rd_eot | output | 1 | Head byte is last of its transfer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| stat_en | output | 1 | Current enable |
| stat_pass | output | 1 | Current pass-through select |
| stat_empty | output | 1 | Pipeline holds no byte |
| stat_irq | output | 2 | Sticky status: bit 0 record read out, bit 1 transfer read out |
| irq | output | 1 | Masked interrupt |
| dict_clr | output | 1 | One-cycle dictionary clear pulse |

## Verification
The first stream is a single record with a reader that is always ready. It shows the three-edge latency and the decode transform, and it keeps the decode path apart from pass-through. A second stream in pass-through mode, with the reader stalled for a while, fills the output FIFO. This tells the full-FIFO freeze apart from an empty-input bubble, and a later trickle of single bytes with gaps covers the empty-input case. Back-to-back records with halt-at-record, and then back-to-back transfers with halt-at-transfer, trap bytes of the next record. Mode writes are then tried while disabled but not empty, which separates the two-condition gate from a gate on enable alone. A reference model in the bench predicts every output on every clock.

// File: rtl/dcc_pkg.sv
// Shared constants for the decompression channel controller.
// Assumes a 2-bit configuration address and an 8-bit write data word.
package dcc_pkg;
    localparam int unsigned CFG_AW = 2;
    localparam int unsigned CFG_DW = 8;
    localparam int unsigned ST_W   = 2;

    typedef enum logic [CFG_AW-1:0] {
        ADR_CTRL = 2'd0,   // bit0 enable, bit1 halt at record, bit2 halt at transfer
        ADR_MODE = 2'd1,   // bit0 pass-through select
        ADR_STAT = 2'd2,   // write-one-to-clear status
        ADR_MASK = 2'd3    // interrupt mask
    } cfg_adr_e;

    localparam int unsigned ST_REC = 0;
    localparam int unsigned ST_XFR = 1;
endpackage

// File: rtl/dcc_pipe.sv
// Tagged byte pipeline of STAGES registers, all advancing together.
// The entry into the last stage takes the decode hook result unless
// pass-through is selected. Assumes STAGES >= 2 and that pass changes
// only while the pipeline is empty.
module dcc_pipe #(
    parameter int unsigned DW     = 8,
    parameter int unsigned STAGES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          pass,
    input  logic          in_v,
    input  logic [DW-1:0] in_d,
    input  logic          in_eor,
    input  logic          in_eot,
    output logic [DW-1:0] xf_in,
    input  logic [DW-1:0] xf_out,
    output logic          out_v,
    output logic [DW-1:0] out_d,
    output logic          out_eor,
    output logic          out_eot,
    output logic          busy
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] v_q, eor_q, eot_q;
    logic [STAGES-1:0] v_n, eor_n, eot_n;
    logic [DW-1:0]     d_q [STAGES];
    logic [DW-1:0]     d_n [STAGES];

    // Next-value selection for each stage: head takes input, last takes decoded byte.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign v_n[g]   = in_v;
            assign eor_n[g] = in_v & in_eor;
            assign eot_n[g] = in_v & in_eot;
            assign d_n[g]   = in_d;
        end else if (g == LAST) begin : g_dec
            assign v_n[g]   = v_q[g-1];
            assign eor_n[g] = eor_q[g-1];
            assign eot_n[g] = eot_q[g-1];
            assign d_n[g]   = pass ? d_q[g-1] : xf_out;
        end else begin : g_mid
            assign v_n[g]   = v_q[g-1];
            assign eor_n[g] = eor_q[g-1];
            assign eot_n[g] = eot_q[g-1];
            assign d_n[g]   = d_q[g-1];
        end
    end

    // Stage registers: shift on advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= '0;
            eor_q <= '0;
            eot_q <= '0;
            for (int i = 0; i < STAGES; i++) d_q[i] <= '0;
        end else if (adv) begin
            v_q   <= v_n;
            eor_q <= eor_n;
            eot_q <= eot_n;
            for (int i = 0; i < STAGES; i++) d_q[i] <= d_n[i];
        end
    end

    assign xf_in   = d_q[LAST-1];
    assign out_v   = v_q[LAST];
    assign out_d   = d_q[LAST];
    assign out_eor = eor_q[LAST];
    assign out_eot = eot_q[LAST];
    assign busy    = |v_q;

    // A frozen pipeline keeps its occupancy (trapped bytes stay put).
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(v_q));
endmodule

// File: rtl/dcc_ofifo.sv
// Output FIFO of DEPTH tagged bytes with a show-ahead head.
// Assumes the writer never writes while full and the reader never reads while empty.
module dcc_ofifo #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wr_d,
    input  logic          wr_eor,
    input  logic          wr_eot,
    input  logic          rd,
    output logic [DW-1:0] rd_d,
    output logic          rd_eor,
    output logic          rd_eot,
    output logic          full,
    output logic          empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned EW = DW + 2;

    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;

    // Storage write; no reset needed since the count guards visibility.
    always_ff @(posedge clk) begin
        if (wr) mem[wp_q] <= {wr_eot, wr_eor, wr_d};
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
            if (rd) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
            case ({wr, rd})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign {rd_eot, rd_eor, rd_d} = mem[rp_q];
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> !full);
    assert_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> !empty);
endmodule

// File: rtl/dcc_ctrl.sv
// Configuration and status registers of the channel: enable with halt
// options, gated pass-through select with clear pulse, sticky status and mask.
// Assumes decode events arrive only on edges where a byte enters the output FIFO.
module dcc_ctrl
    import dcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              pipe_busy,
    input  logic              dec_eor,
    input  logic              dec_eot,
    input  logic              rd_eor_evt,
    input  logic              rd_eot_evt,
    output logic              en,
    output logic              pass,
    output logic              dict_clr,
    output logic [ST_W-1:0]   status,
    output logic              irq
);
    logic              en_q, hrec_q, hxfr_q, pass_q, clr_q;
    logic [ST_W-1:0]   st_q, mask_q;
    logic              wr_ctrl, wr_mode, wr_stat, wr_mask;
    logic              halt_hit, mode_chg;
    logic [ST_W-1:0]   st_set, st_clr;

    // Address decode of the single write strobe.
    always_comb begin
        wr_ctrl = cfg_we && (cfg_addr == ADR_CTRL);
        wr_mode = cfg_we && (cfg_addr == ADR_MODE);
        wr_stat = cfg_we && (cfg_addr == ADR_STAT);
        wr_mask = cfg_we && (cfg_addr == ADR_MASK);
    end

    // Halt condition and gated mode change.
    always_comb begin
        halt_hit = (dec_eor && hrec_q) || (dec_eot && hxfr_q);
        mode_chg = wr_mode && !en_q && !pipe_busy && (cfg_wdata[0] != pass_q);
    end

    // Status set and clear vectors.
    always_comb begin
        st_set         = '0;
        st_set[ST_REC] = rd_eor_evt;
        st_set[ST_XFR] = rd_eot_evt;
        st_clr         = wr_stat ? cfg_wdata[ST_W-1:0] : '0;
    end

    // Enable and halt options; a halt overrides a same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            hrec_q <= 1'b0;
            hxfr_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= cfg_wdata[0];
                hrec_q <= cfg_wdata[1];
                hxfr_q <= cfg_wdata[2];
            end
            if (halt_hit) en_q <= 1'b0;
        end
    end

    // Pass-through select and its one-cycle dictionary clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            if (mode_chg) pass_q <= cfg_wdata[0];
            clr_q <= mode_chg;
        end
    end

    // Sticky status with write-one-to-clear, set winning; interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            mask_q <= '0;
        end else begin
            st_q <= (st_q & ~st_clr) | st_set;
            if (wr_mask) mask_q <= cfg_wdata[ST_W-1:0];
        end
    end

    assign en       = en_q;
    assign pass     = pass_q;
    assign dict_clr = clr_q;
    assign status   = st_q;
    assign irq      = |(st_q & mask_q);

    assert_mode_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass_q) |-> $past(!en_q && !pipe_busy));
    assert_clr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q == !$stable(pass_q));
    assert_halt_rec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_eor && hrec_q) |=> !en_q);
    assert_halt_xfr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_eot && hxfr_q) |=> !en_q);
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[ST_REC] && !st_clr[ST_REC]) |=> st_q[ST_REC]);
endmodule

// File: rtl/dcc_chan_ctrl.sv
// Top of the decompression channel controller: joins the input pop logic,
// the tagged pipeline, the output FIFO and the register block.
// Assumes the input FIFO shows its head byte while in_empty is low.
module dcc_chan_ctrl
    import dcc_pkg::*;
#(
    parameter int unsigned DW       = 8,
    parameter int unsigned STAGES   = 3,
    parameter int unsigned OF_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_empty,
    input  logic [DW-1:0]     in_data,
    input  logic              in_eor,
    input  logic              in_eot,
    output logic              in_pop,
    output logic [DW-1:0]     xf_in,
    input  logic [DW-1:0]     xf_out,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              rd_eor,
    output logic              rd_eot,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              stat_en,
    output logic              stat_pass,
    output logic              stat_empty,
    output logic [ST_W-1:0]   stat_irq,
    output logic              irq,
    output logic              dict_clr
);
    logic          en, pass, busy, adv, of_full, of_empty, rd_fire, wr_fire;
    logic          p_v, p_eor, p_eot;
    logic [DW-1:0] p_d;

    // Flow control: advance when enabled and the output has room.
    always_comb begin
        adv     = en && !of_full;
        in_pop  = adv && !in_empty;
        wr_fire = adv && p_v;
        rd_fire = rd_en && !of_empty;
    end

    dcc_pipe #(.DW(DW), .STAGES(STAGES)) u_pipe (
        .clk(clk), .rst_n(rst_n), .adv(adv), .pass(pass),
        .in_v(in_pop), .in_d(in_data), .in_eor(in_eor), .in_eot(in_eot),
        .xf_in(xf_in), .xf_out(xf_out),
        .out_v(p_v), .out_d(p_d), .out_eor(p_eor), .out_eot(p_eot),
        .busy(busy)
    );

    dcc_ofifo #(.DW(DW), .DEPTH(OF_DEPTH)) u_ofifo (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_fire), .wr_d(p_d), .wr_eor(p_eor), .wr_eot(p_eot),
        .rd(rd_fire), .rd_d(rd_data), .rd_eor(rd_eor), .rd_eot(rd_eot),
        .full(of_full), .empty(of_empty)
    );

    dcc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pipe_busy(busy),
        .dec_eor(wr_fire && p_eor), .dec_eot(wr_fire && p_eot),
        .rd_eor_evt(rd_fire && rd_eor), .rd_eot_evt(rd_fire && rd_eot),
        .en(en), .pass(pass), .dict_clr(dict_clr), .status(stat_irq), .irq(irq)
    );

    assign rd_valid   = !of_empty;
    assign stat_en    = en;
    assign stat_pass  = pass;
    assign stat_empty = !busy;

    assert_pop_room_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_pop |-> (stat_en && !in_empty));
endmodule

// File: tb/dcc_chan_ctrl_test.sv
`timescale 1ns/1ps
module dcc_chan_ctrl_test;
    localparam int DEPTH = 4;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       in_empty = 1'b1, in_eor = 1'b0, in_eot = 1'b0, rd_en = 1'b0;
    logic [7:0] in_data = '0, xf_out, xf_in, rd_data, cfg_wdata = '0;
    logic [1:0] cfg_addr = '0, stat_irq;
    logic       cfg_we = 1'b0;
    logic       in_pop, rd_valid, rd_eor, rd_eot, stat_en, stat_pass, stat_empty, irq, dict_clr;

    int vectors = 0, fails = 0;

    // Reference model state
    int src[$];
    int ofq[$];
    int pipe[3];
    bit m_en, m_hr, m_hx, m_pass, m_dclr;
    bit [1:0] m_st, m_ie;

    always #4 clk = ~clk;

    assign xf_out = xf_in ^ 8'hA5;

    dcc_chan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .in_empty(in_empty), .in_data(in_data),
        .in_eor(in_eor), .in_eot(in_eot), .in_pop(in_pop),
        .xf_in(xf_in), .xf_out(xf_out), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_eor(rd_eor), .rd_eot(rd_eot),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .stat_en(stat_en), .stat_pass(stat_pass), .stat_empty(stat_empty),
        .stat_irq(stat_irq), .irq(irq), .dict_clr(dict_clr)
    );

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_empty();
        return (pipe[0] < 0) && (pipe[1] < 0) && (pipe[2] < 0);
    endfunction

    // Compare every output against the model's prediction for this cycle.
    task automatic compare();
        bit adv, pop;
        adv = m_en && (ofq.size() < DEPTH);
        pop = adv && (src.size() > 0);
        chk("R1 in_pop", in_pop, pop);
        chk("R12 rd_valid", rd_valid, ofq.size() > 0);
        if (ofq.size() > 0) begin
            chk("R2 rd_data", rd_data, ofq[0] & 255);
            chk("R2 rd tags", {rd_eot, rd_eor}, (ofq[0] >> 8) & 3);
        end
        chk("R5 R6 stat_en", stat_en, m_en);
        chk("R3 stat_pass", stat_pass, m_pass);
        chk("R7 stat_empty", stat_empty, m_empty());
        chk("R8 R9 stat_irq", stat_irq, m_st);
        chk("R10 irq", irq, |(m_st & m_ie));
        chk("R4 dict_clr", dict_clr, m_dclr);
    endtask

    // Advance the model by one clock edge using the inputs of this cycle.
    task automatic model_edge();
        bit adv, pop, e0, en0, hr0, hx0;
        bit [1:0] set, clr;
        int outi, newi, h, d;
        adv = m_en && (ofq.size() < DEPTH);
        pop = adv && (src.size() > 0);
        e0 = m_empty(); en0 = m_en; hr0 = m_hr; hx0 = m_hx;
        set = 2'b00; clr = 2'b00; outi = -1; newi = -1;
        if (rd_en && ofq.size() > 0) begin
            h = ofq.pop_front();
            set = 2'((h >> 8) & 3);
        end
        if (adv) begin
            outi = pipe[2];
            if (pop) newi = src.pop_front();
            pipe[2] = pipe[1]; pipe[1] = pipe[0]; pipe[0] = newi;
            if (outi >= 0) begin
                d = outi & 255;
                if (!m_pass) d = d ^ 'hA5;
                ofq.push_back((outi & 'h300) | d);
            end
        end
        m_dclr = 1'b0;
        if (cfg_we) begin
            case (cfg_addr)
                2'd0: begin m_en = cfg_wdata[0]; m_hr = cfg_wdata[1]; m_hx = cfg_wdata[2]; end
                2'd1: if (!en0 && e0 && cfg_wdata[0] != m_pass) begin
                          m_pass = cfg_wdata[0]; m_dclr = 1'b1;
                      end
                2'd2: clr = cfg_wdata[1:0];
                default: m_ie = cfg_wdata[1:0];
            endcase
        end
        if (outi >= 0 && ((hr0 && outi[8]) || (hx0 && outi[9]))) m_en = 1'b0;
        m_st = (m_st & ~clr) | set;
    endtask

    // One cycle: present source head, compare, clock, clear strobes.
    task automatic step();
        in_empty = (src.size() == 0);
        in_data  = (src.size() > 0) ? 8'(src[0] & 255) : 8'h00;
        in_eor   = (src.size() > 0) ? src[0][8] : 1'b0;
        in_eot   = (src.size() > 0) ? src[0][9] : 1'b0;
        #1;
        compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) step();
    endtask

    task automatic cfg(int a, int v);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 8'(v);
        step();
    endtask

    task automatic push_rec(int n, int base, bit eot);
        for (int i = 0; i < n; i++) begin
            int t;
            t = (base + i) & 255;
            if (i == n - 1) t = t | 'h100 | (eot ? 'h200 : 0);
            src.push_back(t);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 300; i++) begin
            if (src.size() == 0 && m_empty() && ofq.size() == 0) break;
            step();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) pipe[i] = -1;
        m_en = 0; m_hr = 0; m_hx = 0; m_pass = 0; m_dclr = 0; m_st = 0; m_ie = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: reset state
        chk("R11 stat_en", stat_en, 0);
        chk("R11 stat_pass", stat_pass, 0);
        chk("R11 stat_empty", stat_empty, 1);
        chk("R11 rd_valid", rd_valid, 0);
        chk("R11 stat_irq", stat_irq, 0);
        chk("R11 irq/dict_clr", {irq, dict_clr}, 0);

        // R1 R2 R8 R10: decode-mode record, reader always ready
        cfg(3, 3);
        cfg(0, 1);
        rd_en = 1'b1;
        push_rec(5, 'h10, 0);
        drain();
        cfg(2, 1);                 // R9 clear record status
        cfg(1, 1);                 // R3 ignored while enabled
        // R4: disable, switch to pass-through, then stream a transfer
        cfg(0, 0);
        cfg(1, 1);
        cfg(1, 1);                 // same value, no pulse
        cfg(0, 1);
        push_rec(4, 'h40, 1);
        drain();
        cfg(2, 3);
        // R1 R12: output stall fills the FIFO and freezes the pipeline
        rd_en = 1'b0;
        push_rec(10, 'h60, 0);
        run(14);
        rd_en = 1'b1;
        drain();
        cfg(2, 3);
        // R5 R7: halt at record with next record trapped
        cfg(0, 3);
        push_rec(4, 'h80, 0);
        push_rec(4, 'h90, 0);
        run(16);
        cfg(1, 0);                 // R3 ignored: disabled but not empty
        run(3);
        cfg(0, 1);
        drain();
        // R4: enable toggle gives no pulse
        cfg(0, 0);
        cfg(0, 1);
        // R6: halt at transfer
        cfg(0, 5);
        push_rec(3, 'hA0, 0);
        push_rec(3, 'hB0, 1);
        push_rec(2, 'hC0, 0);
        run(20);
        cfg(0, 1);
        drain();
        // R1: trickle with empty-input gaps, and reads with alternating strobe
        for (int i = 0; i < 6; i++) begin
            push_rec(1, 'hD0 + i, i == 5);
            run(2);
            rd_en = ~rd_en;
        end
        rd_en = 1'b1;
        drain();
        cfg(2, 3);
        // R9: set and clear in one cycle; drive until record read coincides
        push_rec(2, 'hE0, 0);
        run(4);
        cfg(2, 1);
        run(3);
        // R12: read strobe on empty FIFO has no effect
        rd_en = 1'b1;
        run(4);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule